// File: doc/BRIEF.md
# Retire-Gated Store Queue with Ordered Cache Commit

This block is a circular queue that holds the stores of an out-of-order core between issue and the moment they become visible in the L1 data cache. The front end reserves one slot per store, in program order, at issue. The queue reports the slot index it hands out. The execution units later fill in the store's address and its data. These two writes are independent and each arrives whenever its operation executes, so slots fill in any order.

Retirement is signalled one store at a time. Each retire pulse marks the oldest store that has not yet retired as non-speculative. Only the oldest slot can be offered to the cache, and only when it has retired and holds both address and data. The cache write port uses a valid/ready handshake, so ordering among stores is kept and no store is seen before it retires. A flush, raised on a misprediction or exception, discards every slot that has not retired. The allocation point rolls back to just past the youngest retired store, and the retired stores keep draining.

Top module: `stq_commit`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `cm_valid`=0 and `alloc_idx`=0.
- R2: Accepted allocations take slot indices 0,1,2,… modulo DEPTH. After DEPTH outstanding allocations `full` is 1, and while full an allocation request is ignored and leaves `alloc_idx` unchanged.
- R3: A slot with both address and data written is not offered to the cache (`cm_valid`=0) until it has retired.
- R4: A retired slot is not offered until both its address and its data have been written, in either order.
- R5: Cache writes appear on `cm_addr`/`cm_data` in program order, oldest first, whatever order the slots were filled or retired in.
- R6: While `cm_valid`=1 and `cm_ready`=0, the request stays valid and its address and data stay unchanged. The oldest slot is released only on a cycle with both high.
- R7: A flush discards all non-retired slots. The next allocation index becomes the one just past the youngest retired store, and retired stores are still written to the cache.
- R8: An address or data write to a slot index that is not currently allocated is ignored and does not make that slot eligible after it is later allocated.
- R9: A retire pulse when no allocated store is awaiting retirement is ignored, and it does not retire a store allocated afterwards.
- R10: An allocation request in the same cycle as a flush is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Reserve the next slot for a newly issued store |
| alloc_idx | output | $clog2(DEPTH) | Slot index the next accepted allocation receives |
| full | output | 1 | All slots in use |
| empty | output | 1 | No slot in use |
| addr_we | input | 1 | Store-address write strobe |
| addr_idx | input | $clog2(DEPTH) | Slot targeted by the address write |
| addr_val | input | AW | Store address |
| data_we | input | 1 | Store-data write strobe |
| data_idx | input | $clog2(DEPTH) | Slot targeted by the data write |
| data_val | input | DW | Store data |
| retire | input | 1 | Marks the oldest non-retired store as retired |
| flush | input | 1 | Discard every non-retired store |
| cm_valid | output | 1 | Cache write request for the oldest slot |
| cm_ready | input | 1 | Cache accepts the write this cycle |
| cm_addr | output | AW | Address of the cache write |
| cm_data | output | DW | Data of the cache write |

## Verification
The assertions check the cycle-level invariants on every cycle. The full and empty flags are never both set. An empty queue never requests a write. A full queue keeps its allocation index unless flushed. A stalled cache request holds its value. An accepted write frees a slot. Program ordering across fills, the hiding of unretired stores, the roll-back after a flush and the ignored writes, retires and allocations can only be shown by the bench's scenarios. These scenarios include a sweep of every retired-count before a flush at the wrapped positions of a four-slot queue.

// File: rtl/stq_commit.sv
module stq_commit #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_req,
  output logic [$clog2(DEPTH)-1:0] alloc_idx,
  output logic                     full,
  output logic                     empty,
  input  logic                     addr_we,
  input  logic [$clog2(DEPTH)-1:0] addr_idx,
  input  logic [AW-1:0]            addr_val,
  input  logic                     data_we,
  input  logic [$clog2(DEPTH)-1:0] data_idx,
  input  logic [DW-1:0]            data_val,
  input  logic                     retire,
  input  logic                     flush,
  output logic                     cm_valid,
  input  logic                     cm_ready,
  output logic [AW-1:0]            cm_addr,
  output logic [DW-1:0]            cm_data
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;

  logic [PW-1:0]    head_q, rptr_q, tail_q, rptr_n;
  logic [AW-1:0]    addr_mem [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];
  logic [DEPTH-1:0] av_q, dv_q, kill, set_a, set_d;
  logic [PW-1:0]    used, unret, keep;
  logic [IW-1:0]    hidx;
  logic             alloc_go, ret_go, pop;

  assign used      = tail_q - head_q;
  assign unret     = tail_q - rptr_q;
  assign hidx      = head_q[IW-1:0];
  assign full      = used == PW'(DEPTH);
  assign empty     = used == '0;
  assign alloc_idx = tail_q[IW-1:0];
  assign alloc_go  = alloc_req && !full && !flush;
  assign ret_go    = retire && unret != '0;
  assign rptr_n    = rptr_q + PW'(ret_go);
  assign keep      = rptr_n - head_q;
  assign cm_valid  = rptr_q != head_q && av_q[hidx] && dv_q[hidx];
  assign cm_addr   = addr_mem[hidx];
  assign cm_data   = data_mem[hidx];
  assign pop       = cm_valid && cm_ready;

  function automatic logic below(input logic [IW-1:0] idx, input logic [IW-1:0] base,
                                 input logic [PW-1:0] lim);
    logic [IW-1:0] off;
    off = idx - base;
    return {1'b0, off} < lim;
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      kill[i]  = (pop && hidx == IW'(i)) ||
                 (flush && below(IW'(i), hidx, used) && !below(IW'(i), hidx, keep));
      set_a[i] = addr_we && addr_idx == IW'(i) && below(IW'(i), hidx, used);
      set_d[i] = data_we && data_idx == IW'(i) && below(IW'(i), hidx, used);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      rptr_q <= '0;
      tail_q <= '0;
      av_q   <= '0;
      dv_q   <= '0;
    end else begin
      if (pop) head_q <= head_q + PW'(1);
      rptr_q <= rptr_n;
      if (flush)         tail_q <= rptr_n;
      else if (alloc_go) tail_q <= tail_q + PW'(1);
      for (int i = 0; i < DEPTH; i++) begin
        if (kill[i])       av_q[i] <= 1'b0;
        else if (set_a[i]) av_q[i] <= 1'b1;
        if (kill[i])       dv_q[i] <= 1'b0;
        else if (set_d[i]) dv_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (set_a[i]) addr_mem[i] <= addr_val;
      if (set_d[i]) data_mem[i] <= data_val;
    end
  end
endmodule

// File: rtl/stq_commit_chk.sv
module stq_commit_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     alloc_req,
  input logic                     flush,
  input logic                     addr_we,
  input logic                     data_we,
  input logic                     full,
  input logic                     empty,
  input logic [$clog2(DEPTH)-1:0] alloc_idx,
  input logic                     cm_valid,
  input logic                     cm_ready,
  input logic [AW-1:0]            cm_addr,
  input logic [DW-1:0]            cm_data
);
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r1_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !cm_valid);

  a_r2_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full && !flush |=> alloc_idx == $past(alloc_idx));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !cm_ready && !addr_we && !data_we
      |=> cm_valid && $stable(cm_addr) && $stable(cm_data));

  a_r5_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && cm_ready && !alloc_req && !flush |=> !full);
endmodule

bind stq_commit stq_commit_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .flush(flush),
  .addr_we(addr_we), .data_we(data_we), .full(full), .empty(empty),
  .alloc_idx(alloc_idx), .cm_valid(cm_valid), .cm_ready(cm_ready),
  .cm_addr(cm_addr), .cm_data(cm_data)
);

// File: tb/sim_stq_commit.sv
module sim_stq_commit;
  localparam int D  = 4;
  localparam int IW = 2;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0, alloc_req = 0, addr_we = 0, data_we = 0, retire = 0, flush = 0, cm_ready = 0;
  logic [IW-1:0] addr_idx = 0, data_idx = 0, alloc_idx;
  logic [15:0] addr_val = 0, data_val = 0, cm_addr, cm_data;
  logic full, empty, cm_valid;

  stq_commit #(.DEPTH(D), .AW(16), .DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_idx(alloc_idx),
    .full(full), .empty(empty), .addr_we(addr_we), .addr_idx(addr_idx),
    .addr_val(addr_val), .data_we(data_we), .data_idx(data_idx), .data_val(data_val),
    .retire(retire), .flush(flush), .cm_valid(cm_valid), .cm_ready(cm_ready),
    .cm_addr(cm_addr), .cm_data(cm_data));

  int tests = 0, fails = 0;
  int nseq = 0, bt = 0, rt = 0, qw = 0, qr = 0;
  int seq_of [D];
  int expq [256];

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  function automatic logic [15:0] a_of(input int s); return 16'h1000 + 16'(s); endfunction
  function automatic logic [15:0] d_of(input int s); return 16'h5A00 + 16'(s); endfunction

  task automatic alloc1;
    chk("R2 alloc index", int'(alloc_idx), bt % D);
    alloc_req = 1; tick; alloc_req = 0;
    seq_of[bt % D] = nseq; nseq++; bt++;
  endtask

  task automatic wa(input int idx, input logic [15:0] v);
    addr_we = 1; addr_idx = IW'(idx); addr_val = v; tick; addr_we = 0;
  endtask

  task automatic wd(input int idx, input logic [15:0] v);
    data_we = 1; data_idx = IW'(idx); data_val = v; tick; data_we = 0;
  endtask

  task automatic fill(input int idx, input bit data_first);
    if (data_first) begin wd(idx, d_of(seq_of[idx])); wa(idx, a_of(seq_of[idx])); end
    else begin wa(idx, a_of(seq_of[idx])); wd(idx, d_of(seq_of[idx])); end
  endtask

  task automatic ret1;
    retire = 1; tick; retire = 0;
    expq[qw % 256] = seq_of[rt % D]; qw++; rt++;
  endtask

  task automatic flush1;
    flush = 1; tick; flush = 0; bt = rt;
  endtask

  task automatic drain;
    cm_ready = 1;
    for (int k = 0; k < 20 && !empty; k++) tick;
    cm_ready = 0;
    chk("R5 drained empty", int'(empty), 1);
    chk("R5 every retired store written", qr, qw);
  endtask

  always @(negedge clk) begin
    if (rst_n && cm_valid && cm_ready) begin
      chk("R5 commit addr order", int'(cm_addr), int'(a_of(expq[qr % 256])));
      chk("R5 commit data order", int'(cm_data), int'(d_of(expq[qr % 256])));
      qr++;
    end
  end

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] ha, hd;
    repeat (3) tick;
    rst_n = 1; tick;
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 cm_valid", int'(cm_valid), 0);
    chk("R1 alloc_idx", int'(alloc_idx), 0);

    for (int i = 0; i < D; i++) alloc1();
    chk("R2 full after DEPTH", int'(full), 1);
    alloc_req = 1; tick; alloc_req = 0;
    chk("R2 index held when full", int'(alloc_idx), 0);
    chk("R2 still full", int'(full), 1);

    for (int i = D - 1; i >= 0; i--) fill(i, i[0]);
    chk("R3 complete but unretired", int'(cm_valid), 0);
    ret1();
    chk("R5 oldest offered", int'(cm_valid), 1);
    chk("R5 oldest addr", int'(cm_addr), int'(a_of(seq_of[0])));
    ha = cm_addr; hd = cm_data;
    repeat (3) tick;
    chk("R6 stall valid", int'(cm_valid), 1);
    chk("R6 stall addr", int'(cm_addr), int'(ha));
    chk("R6 stall data", int'(cm_data), int'(hd));
    for (int i = 1; i < D; i++) ret1();
    drain();

    alloc1(); ret1();
    chk("R4 retired, nothing written", int'(cm_valid), 0);
    wa((bt - 1) % D, a_of(seq_of[(bt - 1) % D]));
    chk("R4 address only", int'(cm_valid), 0);
    wd((bt - 1) % D, d_of(seq_of[(bt - 1) % D]));
    chk("R4 both written", int'(cm_valid), 1);
    drain();

    wa(bt % D, 16'hDEAD); wd(bt % D, 16'hBEEF);
    alloc1(); ret1();
    chk("R8 stale write ignored", int'(cm_valid), 0);
    fill((bt - 1) % D, 1'b0);
    chk("R8 real write accepted", int'(cm_valid), 1);
    drain();

    retire = 1; tick; retire = 0;
    alloc1(); fill((bt - 1) % D, 1'b1);
    chk("R9 spare retire ignored", int'(cm_valid), 0);
    ret1();
    drain();

    alloc1();
    alloc_req = 1; flush = 1; tick; alloc_req = 0; flush = 0; bt = rt;
    chk("R10 alloc during flush ignored", int'(alloc_idx), bt % D);
    chk("R7 flushed queue empty", int'(empty), 1);

    for (int nret = 0; nret <= D; nret++) begin
      for (int k = 0; k < D; k++) alloc1();
      for (int k = D - 1; k >= 0; k--) fill((rt + k) % D, k[0]);
      for (int k = 0; k < nret; k++) ret1();
      chk("R3 retired head offered", int'(cm_valid), nret > 0 ? 1 : 0);
      flush1();
      chk("R7 rollback index", int'(alloc_idx), bt % D);
      chk("R7 full after flush", int'(full), nret == D ? 1 : 0);
      chk("R7 empty after flush", int'(empty), nret == 0 ? 1 : 0);
      drain();
    end

    summary();
    $finish;
  end
endmodule